// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

A shared monitor that sits in front of one memory port used by several requesters. It tracks the atomic read-modify-write sequences those requesters make. A load-linked records a reservation for its requester on a 64-byte line. A later store-conditional from the same requester writes only if that reservation is still held.

Reservations are removed only by a write that really happens. That write is either an ordinary store or a store-conditional that succeeds. A store-conditional that fails changes nothing. The first requester to reach the port with a matching store-conditional always wins, so racing requesters cannot undo each other's work and the system cannot livelock.

Requests arrive one per cycle from an upstream arbiter. Each request gets a pass/fail answer in the following cycle.

**Slot state machine.** Each requester owns one slot, which has two states:
- `SLOT_EMPTY`: no reservation is held. The *arm* transition (own load-linked) moves the slot to `SLOT_HELD`.
- `SLOT_HELD`: a reservation is held. The *rearm* transition (own load-linked) stays in `SLOT_HELD` and replaces the line. The *kill* transition (a real write to the held line) returns the slot to `SLOT_EMPTY`.

**Response state machine.** It has three states:
- `RSP_IDLE`: no request was taken in the last cycle.
- `RSP_PASS`: the previous request succeeded.
- `RSP_FAIL`: the previous request failed.

Each cycle it takes the *fire* transition to `RSP_PASS` or `RSP_FAIL` when a request is present. Otherwise it takes the *quiet* transition to `RSP_IDLE`.

Top module: `resv_monitor`

## Requirements
- R1: The op codes are 00 plain load, 01 load-linked, 10 store-conditional and 11 ordinary store. A load-linked from requester r records a reservation for r on the line `req_addr[ADDR_W-1:6]`. It replaces any earlier reservation held by r and answers with ok=1.
- R2: A store-conditional from r answers ok=1 only when r holds a reservation on the same line. Address bits 5:0 are ignored in this comparison.
- R3: A successful store-conditional is a write. It removes every reservation on its line, including the issuer's own.
- R4: A failed store-conditional leaves every reservation unchanged, both its own and those of other requesters.
- R5: An ordinary store from any requester answers ok=1 and removes every reservation on its line.
- R6: Writes and store-conditionals never disturb reservations held on other lines.
- R7: When several requesters hold reservations on one line, the first store-conditional processed succeeds and the later ones fail.
- R8: After reset no slot holds a reservation, so every store-conditional fails until a load-linked arms it. `rsp_valid` is 0 during reset.
- R9: Each cycle with `req_valid`=1 produces `rsp_valid`=1 in the next cycle. A cycle without a request produces `rsp_valid`=0. A plain load answers ok=1 and has no effect on reservations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 00 load, 01 load-linked, 10 store-conditional, 11 store |
| req_id | input | ID_W | Issuing requester |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_ok | output | 1 | Pass (1) or fail (0) |

## Verification
The hardest situation to reach is a failed store-conditional while other requesters hold reservations on the same line. Reservations cannot be seen at the ports, so whether they survived has to be probed afterwards. The bench arms several slots, issues the losing store-conditional, and then sends a store-conditional from each requester in turn, so that the pass/fail pattern shows exactly which slots are still held. A sweep over actor, operation, self-armed state and same or other line does the same for every combination. A long pseudo-random stream over three lines then checks races against an arithmetic model kept in the bench.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_LINK  = 2'b01,
        OP_COND  = 2'b10,
        OP_STORE = 2'b11
    } resv_op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'b00,
        RSP_PASS = 2'b01,
        RSP_FAIL = 2'b10
    } rsp_state_e;

endpackage

// File: rtl/rsvm_slot.sv
module rsvm_slot
    import resv_monitor_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [TAG_W-1:0] arm_tag_i,
    input  logic             kill_i,
    input  logic [TAG_W-1:0] kill_tag_i,
    output logic             held_o,
    output logic [TAG_W-1:0] tag_o
);

    slot_state_e      state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (arm_i) begin
                    state_d = SLOT_HELD;
                    tag_d   = arm_tag_i;
                end
            end
            SLOT_HELD: begin
                if (arm_i) begin
                    tag_d = arm_tag_i;
                end else if (kill_i && (kill_tag_i == tag_q)) begin
                    state_d = SLOT_EMPTY;
                end
            end
        endcase
    end

    always_comb begin
        held_o = (state_q == SLOT_HELD);
        tag_o  = tag_q;
    end

    AST_SLOT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (held_o && tag_o == $past(arm_tag_i)));                 // R1

    AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !kill_i) |=> held_o);                                  // R4

    AST_SLOT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !arm_i && kill_i && kill_tag_i == tag_o) |=> !held_o); // R3

endmodule

// File: rtl/rsvm_decode.sv
module rsvm_decode
    import resv_monitor_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ID_W    = 2,
    parameter int TAG_W   = 26
) (
    input  logic                           req_valid_i,
    input  resv_op_e                       req_op_i,
    input  logic [ID_W-1:0]                req_id_i,
    input  logic [TAG_W-1:0]               req_tag_i,
    input  logic [NUM_REQ-1:0]             held_i,
    input  logic [NUM_REQ-1:0][TAG_W-1:0]  tag_i,
    output logic [NUM_REQ-1:0]             arm_o,
    output logic                           kill_o,
    output logic                           own_held_o,
    output logic                           pass_o
);

    logic [NUM_REQ-1:0] sel;
    logic [NUM_REQ-1:0] own_hit;
    logic               own_match;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_sel
        assign sel[i]     = req_valid_i && (req_id_i == ID_W'(i));
        assign own_hit[i] = sel[i] && held_i[i] && (tag_i[i] == req_tag_i);
        assign arm_o[i]   = sel[i] && (req_op_i == OP_LINK);
    end

    assign own_match  = |own_hit;
    assign own_held_o = |(sel & held_i);

    always_comb begin
        kill_o = 1'b0;
        pass_o = 1'b1;
        unique case (req_op_i)
            OP_LOAD:  pass_o = 1'b1;
            OP_LINK:  pass_o = 1'b1;
            OP_COND: begin
                pass_o = own_match;
                kill_o = req_valid_i && own_match;
            end
            OP_STORE: kill_o = req_valid_i;
        endcase
    end

endmodule

// File: rtl/rsvm_resp.sv
module rsvm_resp
    import resv_monitor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic pass_i,
    output logic rsp_valid_o,
    output logic rsp_ok_o
);

    rsp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = RSP_IDLE;
        if (fire_i) state_d = pass_i ? RSP_PASS : RSP_FAIL;
    end

    always_comb begin
        rsp_valid_o = 1'b0;
        rsp_ok_o    = 1'b0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid_o = 1'b0;
                rsp_ok_o    = 1'b0;
            end
            RSP_PASS: begin
                rsp_valid_o = 1'b1;
                rsp_ok_o    = 1'b1;
            end
            RSP_FAIL: begin
                rsp_valid_o = 1'b1;
                rsp_ok_o    = 1'b0;
            end
            default: begin
                rsp_valid_o = 1'b0;
                rsp_ok_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_monitor_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int ID_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_ok
);

    localparam int TAG_W = ADDR_W - LINE_BITS;

    resv_op_e                       op;
    logic [TAG_W-1:0]               req_tag;
    logic [NUM_REQ-1:0]             held_vec;
    logic [NUM_REQ-1:0][TAG_W-1:0]  tag_vec;
    logic [NUM_REQ-1:0]             arm_vec;
    logic                           kill_en;
    logic                           own_held;
    logic                           req_pass;
    logic                           unused_low;

    assign op         = resv_op_e'(req_op);
    assign req_tag    = req_addr[ADDR_W-1:LINE_BITS];
    assign unused_low = ^req_addr[LINE_BITS-1:0];

    rsvm_decode #(
        .NUM_REQ (NUM_REQ),
        .ID_W    (ID_W),
        .TAG_W   (TAG_W)
    ) decode_i (
        .req_valid_i (req_valid),
        .req_op_i    (op),
        .req_id_i    (req_id),
        .req_tag_i   (req_tag),
        .held_i      (held_vec),
        .tag_i       (tag_vec),
        .arm_o       (arm_vec),
        .kill_o      (kill_en),
        .own_held_o  (own_held),
        .pass_o      (req_pass)
    );

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
        rsvm_slot #(.TAG_W(TAG_W)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm_i      (arm_vec[i]),
            .arm_tag_i  (req_tag),
            .kill_i     (kill_en),
            .kill_tag_i (req_tag),
            .held_o     (held_vec[i]),
            .tag_o      (tag_vec[i])
        );

        AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && op == OP_STORE && held_vec[i] && tag_vec[i] == req_tag)
            |=> !held_vec[i]);                                            // R5

        AST_OTHER_LINE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && op != OP_LINK && held_vec[i] && tag_vec[i] != req_tag)
            |=> (held_vec[i] && $stable(tag_vec[i])));                    // R6
    end

    rsvm_resp resp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (req_valid),
        .pass_i      (req_pass),
        .rsp_valid_o (rsp_valid),
        .rsp_ok_o    (rsp_ok)
    );

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                         // R9

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                       // R9

    AST_FAIL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_COND && !req_pass)
        |=> ($stable(held_vec) && $stable(tag_vec)));                     // R4

    AST_COND_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_COND && !own_held) |=> !rsp_ok);           // R2

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (held_vec == '0));                                     // R8

endmodule

// File: tb/resv_monitor_tb_top.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;

    localparam int NUM_REQ = 4;
    localparam int ADDR_W  = 12;
    localparam int ID_W    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [ID_W-1:0]   req_id = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic              rsp_ok;

    int checks = 0;
    int errors = 0;

    bit mv [NUM_REQ];
    int ml [NUM_REQ];

    always #2.5 clk = ~clk;

    resv_monitor #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .LINE_BITS(6), .ID_W(ID_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_id    (req_id),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok)
    );

    task automatic check(input bit good, input string rq, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual valid/ok=%b expected %b", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int id, input int addr, input string rq);
        int  ln;
        bit  exp;
        ln = addr >> 6;
        req_valid = 1'b1;
        req_op    = op;
        req_id    = id[ID_W-1:0];
        req_addr  = addr[ADDR_W-1:0];
        exp = 1'b1;
        case (op)
            2'b01: begin mv[id] = 1'b1; ml[id] = ln; end
            2'b10: begin
                exp = mv[id] && (ml[id] == ln);
                if (exp) for (int k = 0; k < NUM_REQ; k++) if (ml[k] == ln) mv[k] = 1'b0;
            end
            2'b11: for (int k = 0; k < NUM_REQ; k++) if (ml[k] == ln) mv[k] = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_ok === exp, rq, {rsp_valid, rsp_ok}, {1'b1, exp});
        req_valid = 1'b0;
    endtask

    task automatic idle(input string rq);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, rq, {rsp_valid, rsp_ok}, 2'b00);
    endtask

    task automatic clear_all();
        for (int k = 0; k < NUM_REQ; k++) issue(2'b11, 0, (k * 8 + 1) << 6, "R5");
        for (int line = 0; line < 64; line++) ;
        for (int k = 0; k < NUM_REQ; k++) mv[k] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NUM_REQ; k++) begin mv[k] = 1'b0; ml[k] = 0; end
        repeat (4) @(negedge clk);
        check(rsp_valid === 1'b0, "R8", {rsp_valid, rsp_ok}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: no reservations after reset
        for (int r = 0; r < NUM_REQ; r++) issue(2'b10, r, 12'h140, "R8");
        idle("R9");

        // R2: low six bits ignored, other line fails
        issue(2'b01, 0, 12'h040, "R1");
        issue(2'b10, 0, 12'h07F, "R2");
        issue(2'b01, 0, 12'h080, "R1");
        issue(2'b10, 0, 12'h0C0, "R2");

        // R1: second load-linked replaces first
        issue(2'b01, 1, 12'h100, "R1");
        issue(2'b01, 1, 12'h200, "R1");
        issue(2'b10, 1, 12'h100, "R1");
        issue(2'b10, 1, 12'h200, "R1");

        // R4: failed conditional leaves others intact
        issue(2'b01, 0, 12'h300, "R1");
        issue(2'b01, 1, 12'h300, "R1");
        issue(2'b10, 2, 12'h300, "R4");
        issue(2'b10, 1, 12'h310, "R4");
        issue(2'b10, 0, 12'h300, "R3");

        // R7: race on one line
        for (int r = 0; r < NUM_REQ; r++) issue(2'b01, r, 12'h500 + r, "R1");
        issue(2'b10, 2, 12'h520, "R7");
        issue(2'b10, 0, 12'h500, "R7");
        issue(2'b10, 1, 12'h500, "R7");
        issue(2'b10, 3, 12'h500, "R7");

        // R5 and R6: store hits only its line
        issue(2'b01, 0, 12'h040, "R1");
        issue(2'b01, 1, 12'h080, "R1");
        issue(2'b11, 3, 12'h050, "R5");
        issue(2'b10, 1, 12'h0A0, "R6");
        issue(2'b10, 0, 12'h040, "R5");

        // R9: plain load has no effect
        issue(2'b01, 2, 12'h600, "R1");
        issue(2'b00, 3, 12'h600, "R9");
        idle("R9");
        issue(2'b10, 2, 12'h600, "R9");

        // sweep: actor x op x self-armed x same line, then probe every slot
        for (int a = 0; a < NUM_REQ; a++)
            for (int op = 0; op < 4; op++)
                for (int self = 0; self < 2; self++)
                    for (int same = 0; same < 2; same++) begin
                        clear_all();
                        for (int r = 0; r < NUM_REQ; r++)
                            if (r != a || self == 1) issue(2'b01, r, (7 << 6) + r, "R1");
                        issue(op[1:0], a, same == 1 ? (7 << 6) + 5 : (9 << 6),
                              op == 2 ? "R4" : op == 3 ? "R5" : op == 0 ? "R9" : "R1");
                        for (int r = 0; r < NUM_REQ; r++)
                            issue(2'b10, (r + a) % NUM_REQ, (7 << 6) + 9,
                                  same == 1 ? "R3" : "R6");
                    end

        // pseudo-random race stream over three lines
        for (int n = 0; n < 3000; n++) begin
            int rop, rid, rln;
            rop = $urandom_range(3, 0);
            rid = $urandom_range(NUM_REQ - 1, 0);
            rln = $urandom_range(2, 0);
            issue(rop[1:0], rid, (rln << 6) + $urandom_range(63, 0), "R7");
        end
        idle("R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule